// File: doc/BRIEF.md
# Clocked Burst Serial Port

This block is a synchronous serial port that moves a burst of bytes, from one to eight of them, on a single start command. The host first loads transmit bytes into an eight-slot byte buffer. It then selects the clock source and the select-gated mode, gives a byte count and pulses start. The port shifts each byte out most significant bit first while it shifts a byte in. Each received byte overwrites the slot its transmit byte came from, so after the burst the host reads the replies back in order.

The shift clock is either generated internally or taken from the clock pin. A pin clock passes through a two-stage synchroniser before its edges are detected. In select-gated mode, an armed burst waits for a falling edge on the active-low select input. While select stays low the clock and data pads are driven. When select rises, the pads are released, and a burst that has not finished is abandoned. Pad tri-state is modelled by output-enable signals.

Top module: `sync_burst_serial`

## Requirements
- R1: After reset, sck_o is 1, sck_oe is 0, so_oe is 1, and done, irq and abort are all 0.
- R2: Each wr_en while idle stores wr_data in the next buffer slot, starting at slot 0. A start rewinds both the write pointer and the read pointer to slot 0. The burst sends slot 0 first. Each received byte replaces the slot it was sent from. Each rd_en while idle moves rd_data to the next slot.
- R3: count gives the burst length. Values 1 to 7 move that many bytes, and 0 moves eight bytes. Slots beyond the burst keep their contents.
- R4: With mode_int_clk=1, sck_o idles at 1. For each bit it stays low for 8 clk cycles and then high for 8 clk cycles, so one period is 16 cycles. sck_oe is 1 outside select-gated mode.
- R5: Bits are sent MSB first. so_o holds the first bit from the start of the burst and changes only after a falling shift-clock edge. si is sampled on the rising shift-clock edge.
- R6: After the 8th rising edge of the last byte, done goes to 1 and irq is 1 for exactly one clk cycle. done stays set until the next start.
- R7: With mode_int_clk=0, sck_i is the shift clock and sck_oe is 0. sck_i passes through two flip-flops before edge detection, so each of its phases must last at least 4 clk cycles.
- R8: With mode_cs=1, a started burst waits for a falling edge on cs_n. Until then sck_o stays 1, and sck_oe and so_oe stay 0.
- R9: With mode_cs=1, once cs_n has been high for 3 clk cycles, sck_oe and so_oe are 0.
- R10: If cs_n rises in the middle of a select-gated burst, the burst stops and abort goes to 1 with a one-cycle irq pulse, while done stays 0. Bytes already completed stay in their slots, and the partial byte is dropped.
- R11: mode_int_clk, mode_cs and count are latched at start. A start pulse during a burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Store wr_data in the next buffer slot |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Advance the read pointer |
| rd_data | output | 8 | Buffer slot at the read pointer |
| start | input | 1 | Begin a burst (one-cycle strobe) |
| count | input | 3 | Burst length, 0 meaning eight |
| mode_int_clk | input | 1 | 1: generate shift clock; 0: take it from sck_i |
| mode_cs | input | 1 | 1: burst gated by cs_n |
| done | output | 1 | Burst completed |
| irq | output | 1 | One-cycle pulse at completion or abort |
| abort | output | 1 | Last burst ended early by cs_n rising |
| sck_i | input | 1 | Shift clock from the pin |
| sck_o | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Shift-clock pad drive enable |
| si | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Data pad drive enable |
| cs_n | input | 1 | Active-low select |

## Verification
The properties assume three things about the inputs. cs_n is a clean level that holds for several cycles, so its synchronised copy agrees with the pin after three cycles. An external sck_i holds each phase longer than the synchroniser latency. si stays stable from a rising pin edge until that edge has been detected. The host also leaves the buffer alone and keeps the mode inputs steady around the start pulse. The bench respects all of this. It holds each external clock phase for 6 cycles and changes si only in the low phase. As slave, it changes si only on the clk falling edge after a detected falling shift clock. It moves cs_n in steps separated by many cycles.

// File: rtl/sync_burst_serial.sv
module sync_burst_serial #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int HALF  = 8,
  parameter int CW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  logic          mode_int_clk,
  input  logic          mode_cs,
  output logic          done,
  output logic          irq,
  output logic          abort,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          si,
  output logic          so_o,
  output logic          so_oe,
  input  logic          cs_n
);
  localparam int DW = $clog2(2*HALF);
  localparam int BW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} st_t;
  st_t state;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wptr, rptr, idx, last;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] div;
  logic [W-1:0]  txsh, rxsh;
  logic          cfg_int, cfg_cs, cs_drv;
  logic          k1, k2, k3, c1, c2, c3;

  logic idle, running, rise_ev, fall_ev, cs_fall, rx_done, mem_we;
  logic [CW-1:0] mem_addr;
  logic [W-1:0]  mem_din;

  assign idle    = (state == S_IDLE);
  assign running = (state == S_RUN);
  assign cs_fall = ~c2 & c3;
  assign rise_ev = running & (cfg_int ? (div == DW'(HALF-1))   : (k2 & ~k3));
  assign fall_ev = running & (cfg_int ? (div == DW'(2*HALF-1)) : (~k2 & k3));
  assign rx_done = rise_ev & (bitcnt == BW'(W-1)) & ~(cfg_cs & c2);

  assign mem_we   = (wr_en & idle) | rx_done;
  assign mem_addr = rx_done ? idx : wptr;
  assign mem_din  = rx_done ? {rxsh[W-2:0], si} : wr_data;
  assign rd_data  = mem[rptr];

  assign sck_o  = ~(running & cfg_int) | (div >= DW'(HALF));
  assign so_o   = txsh[W-1];
  assign so_oe  = cfg_cs ? cs_drv : 1'b1;
  assign sck_oe = cfg_int & so_oe;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {k1, k2, k3} <= 3'b111;
      {c1, c2, c3} <= 3'b111;
      cs_drv <= 1'b0;
    end else begin
      {k1, k2, k3} <= {sck_i, k1, k2};
      {c1, c2, c3} <= {cs_n, c1, c2};
      if (c2)                      cs_drv <= 1'b0;
      else if ((state == S_ARM) && cs_fall) cs_drv <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wptr    <= '0;
      rptr    <= '0;
      idx     <= '0;
      last    <= '0;
      bitcnt  <= '0;
      div     <= '0;
      txsh    <= '0;
      rxsh    <= '0;
      cfg_int <= 1'b0;
      cfg_cs  <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
      abort   <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: begin
          if (wr_en) wptr <= wptr + 1'b1;
          if (rd_en) rptr <= rptr + 1'b1;
          if (start) begin
            cfg_int <= mode_int_clk;
            cfg_cs  <= mode_cs;
            last    <= count - 1'b1;
            idx     <= '0;
            wptr    <= '0;
            rptr    <= '0;
            bitcnt  <= '0;
            div     <= '0;
            done    <= 1'b0;
            abort   <= 1'b0;
            txsh    <= mem[0];
            state   <= mode_cs ? S_ARM : S_RUN;
          end
        end
        S_ARM: begin
          if (cs_fall) begin
            div   <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (cfg_cs && c2) begin
            state <= S_IDLE;
            abort <= 1'b1;
            irq   <= 1'b1;
          end else begin
            if (cfg_int) div <= (div == DW'(2*HALF-1)) ? '0 : div + 1'b1;
            if (rise_ev) begin
              rxsh   <= {rxsh[W-2:0], si};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BW'(W-1)) begin
                bitcnt <= '0;
                if (idx == last) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
                  irq   <= 1'b1;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
            end
            if (fall_ev) begin
              if (bitcnt == '0) txsh <= mem[idx];
              else              txsh <= {txsh[W-2:0], 1'b0};
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sync_burst_serial_chk.sv
module sync_burst_serial_chk #(
  parameter int HALF = 8
) (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic done,
  input logic abort,
  input logic sck_o,
  input logic sck_oe,
  input logic so_oe,
  input logic cs_n,
  input logic cfg_cs,
  input logic cfg_int,
  input logic running
);
  localparam int LW = $clog2(2*HALF) + 1;
  logic [LW-1:0] lvl_len;
  logic          sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_len <= '0;
      sck_q   <= 1'b1;
    end else begin
      sck_q <= sck_o;
      if (sck_o != sck_q)      lvl_len <= LW'(1);
      else if (~&lvl_len)      lvl_len <= lvl_len + 1'b1;
    end
  end

  // R6: interrupt is a single-cycle pulse
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: completion raises the interrupt
  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> irq);

  // R4: every generated clock phase inside a burst lasts HALF cycles
  assert_phase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cfg_int && $past(running) && (sck_o != $past(sck_o)))
      |-> (lvl_len == LW'(HALF)));

  // R9: pads released once select has stayed high
  assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cs && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> (!so_oe && !sck_oe));

  // R10: an aborted burst never reports completion
  assert_abort_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abort));
endmodule

bind sync_burst_serial sync_burst_serial_chk #(.HALF(HALF)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .done(done), .abort(abort),
  .sck_o(sck_o), .sck_oe(sck_oe), .so_oe(so_oe), .cs_n(cs_n),
  .cfg_cs(cfg_cs), .cfg_int(cfg_int), .running(running)
);

// File: tb/sync_burst_serial_tb_top.sv
module sync_burst_serial_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, start = 0, mode_int_clk = 1, mode_cs = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] count = '0;
  logic sck_i = 1, si = 0, cs_n = 1;
  logic [7:0] rd_data;
  logic done, irq, abort, sck_o, sck_oe, so_o, so_oe;

  int checks = 0, fails = 0, cyc = 0, irq_seen = 0, irq_wide = 0;
  logic irq_prev = 0;
  logic [7:0] txb [8];
  logic [7:0] rsp [8];
  logic [7:0] got [8];

  always #10 clk = ~clk;

  sync_burst_serial dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .start(start), .count(count), .mode_int_clk(mode_int_clk),
    .mode_cs(mode_cs), .done(done), .irq(irq), .abort(abort), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .si(si), .so_o(so_o), .so_oe(so_oe), .cs_n(cs_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) irq_seen <= irq_seen + 1;
    if (irq && irq_prev) irq_wide <= irq_wide + 1;
    irq_prev <= irq;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (act=%0d exp<150000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = txb[i]; tick(1);
    end
    wr_en = 0;
  endtask

  task automatic pulse_start();
    start = 1; tick(1); start = 0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && !abort && t < 4000) begin tick(1); t++; end
    chk(tag, {31'b0, done}, 32'd1);
  endtask

  task automatic readback(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, {24'b0, rd_data}, {24'b0, rsp[i]});
      rd_en = 1; tick(1); rd_en = 0;
    end
  endtask

  task automatic slave_run(input int n);
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        si = rsp[b][i];
        @(posedge sck_o); @(negedge clk);
        got[b][i] = so_o;
        if (!(b == n-1 && i == 0)) begin
          @(negedge sck_o); @(negedge clk);
        end
      end
  endtask

  task automatic t_reset();
    chk("R1 sck_o", {31'b0, sck_o}, 1);
    chk("R1 sck_oe", {31'b0, sck_oe}, 0);
    chk("R1 so_oe", {31'b0, so_oe}, 1);
    chk("R1 flags", {29'b0, done, irq, abort}, 0);
  endtask

  task automatic t_basic();
    int t0 = 0, t1 = 0, t2 = 0, i0;
    for (int i = 0; i < 3; i++) begin txb[i] = 8'hA1 + 8'(i*17); rsp[i] = 8'h5E ^ 8'(i*29); end
    mode_int_clk = 1; mode_cs = 0; count = 3;
    load(3);
    i0 = irq_seen;
    fork
      slave_run(3);
      pulse_start();
      begin
        @(posedge sck_o); t0 = cyc;
        @(negedge sck_o); t1 = cyc;
        @(posedge sck_o); t2 = cyc;
      end
    join
    wait_done("R6 done basic");
    chk("R4 high phase", t1 - t0, 8);
    chk("R4 period", t2 - t0, 16);
    chk("R4 sck_oe", {31'b0, sck_oe}, 1);
    for (int b = 0; b < 3; b++) chk("R5 msb-first tx", {24'b0, got[b]}, {24'b0, txb[b]});
    tick(3);
    chk("R6 irq once", irq_seen - i0, 1);
    chk("R6 irq width", irq_wide, 0);
    chk("R6 abort clear", {31'b0, abort}, 0);
    readback("R2 rx replaces tx", 3);
  endtask

  task automatic t_count8();
    int i0;
    for (int i = 0; i < 8; i++) begin txb[i] = 8'(8'h10 + i*33); rsp[i] = 8'(8'hC3 - i*7); end
    mode_int_clk = 1; mode_cs = 0; count = 0;
    load(8);
    i0 = irq_seen;
    fork
      slave_run(8);
      begin
        pulse_start();
        tick(300);
        count = 1; mode_int_clk = 0;
        pulse_start();
        count = 0; mode_int_clk = 1;
      end
    join
    wait_done("R3 count0 done");
    for (int b = 0; b < 8; b++) chk("R3 eight bytes sent", {24'b0, got[b]}, {24'b0, txb[b]});
    tick(3);
    chk("R11 start ignored while busy", irq_seen - i0, 1);
    readback("R3 eight bytes received", 8);
  endtask

  task automatic t_count1();
    txb[0] = 8'h81; txb[1] = 8'h7E; rsp[0] = 8'h24; rsp[1] = 8'h7E;
    mode_int_clk = 1; mode_cs = 0; count = 1;
    load(2);
    fork slave_run(1); pulse_start(); join
    wait_done("R3 count1 done");
    chk("R3 one byte sent", {24'b0, got[0]}, 8'h81);
    readback("R3 slot beyond burst kept", 2);
  endtask

  task automatic t_ext();
    txb[0] = 8'hB4; txb[1] = 8'h2D; rsp[0] = 8'h96; rsp[1] = 8'h0F;
    mode_int_clk = 0; mode_cs = 0; count = 2;
    load(2);
    pulse_start();
    tick(4);
    chk("R7 sck_oe off", {31'b0, sck_oe}, 0);
    for (int b = 0; b < 2; b++)
      for (int i = 7; i >= 0; i--) begin
        sck_i = 0; si = rsp[b][i]; tick(6);
        got[b][i] = so_o;
        sck_i = 1; tick(6);
      end
    wait_done("R7 ext done");
    for (int b = 0; b < 2; b++) chk("R7 ext tx", {24'b0, got[b]}, {24'b0, txb[b]});
    readback("R7 ext rx", 2);
  endtask

  task automatic t_cs();
    txb[0] = 8'hE7; txb[1] = 8'h18; rsp[0] = 8'h3A; rsp[1] = 8'hC5;
    mode_int_clk = 1; mode_cs = 1; count = 2; cs_n = 1;
    load(2);
    pulse_start();
    tick(40);
    chk("R8 armed oe", {30'b0, sck_oe, so_oe}, 0);
    chk("R8 armed idle clock", {31'b0, sck_o}, 1);
    chk("R8 not done", {31'b0, done}, 0);
    fork slave_run(2); begin cs_n = 0; tick(5); chk("R8 drive on select", {30'b0, sck_oe, so_oe}, 3); end join
    wait_done("R8 cs done");
    for (int b = 0; b < 2; b++) chk("R8 cs tx", {24'b0, got[b]}, {24'b0, txb[b]});
    cs_n = 1; tick(4);
    chk("R9 release", {30'b0, sck_oe, so_oe}, 0);
    readback("R8 cs rx", 2);
  endtask

  task automatic t_abort();
    int i0;
    txb[0] = 8'hA5; txb[1] = 8'h3C; rsp[0] = 8'hFF; rsp[1] = 8'h3C;
    mode_int_clk = 1; mode_cs = 1; count = 2; cs_n = 1;
    load(2);
    i0 = irq_seen;
    pulse_start();
    tick(5);
    si = 1; cs_n = 0;
    tick(180);
    cs_n = 1;
    tick(6);
    chk("R10 abort set", {31'b0, abort}, 1);
    chk("R10 done clear", {31'b0, done}, 0);
    chk("R10 irq once", irq_seen - i0, 1);
    chk("R9 release after abort", {30'b0, sck_oe, so_oe}, 0);
    readback("R10 partial dropped", 2);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick(2);
    t_basic();
    t_count8();
    t_count1();
    t_ext();
    t_cs();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule